// File: doc/BRIEF.md
# Programmable 16-bit Down-Counting Timer Channel

One channel counts down from a 16-bit time constant and marks the moment it runs out. The host controls it through six byte-wide register slots. A mode byte selects the following:
- whether the channel runs once or keeps reloading itself;
- whether it counts clock cycles or the rising edges of an external count pin;
- whether an external pin may start it;
- whether an external pin may pause it;
- whether a new start may interrupt a run already in progress;
- the shape of the output waveform.

A control/status byte holds the software gate, the software start strobe, the count-freeze request, the running flag and four interrupt flags. The upper three bits of a write to that byte carry an interrupt command.

A typical sequence has four steps. Write the mode byte and the two time-constant bytes. Raise `chan_enable`. Write the control byte with the gate bit set, which arms the channel. Start it with the strobe bit or with an edge on the trigger pin. To read the count without tearing between its two bytes, set the freeze bit, read the high byte, then read the low byte. The read of the low byte ends the freeze.

Register slots on `reg_sel` are as follows: 0 mode, 1 control/status, 2 time-constant high byte, 3 time-constant low byte, 4 count high byte, 5 count low byte. Any other slot reads zero.

Top module: `ctc_channel`

## Requirements
- R1: After synchronous reset, all six register slots read 0x00, and `ct_out` and `irq` are 0.
- R2: Writing slot 1 with bit1 = 1 and bit2 = 1 while `chan_enable` is 1 loads the time constant into the count and sets the running flag (slot 1 bit0) at that clock edge. The write is ignored when bit2 is 0 or `chan_enable` is 0.
- R3: With mode bit5 = 0 the count drops by one on every clock edge while the channel runs. The edge at which the count is 1 (or 0) is the terminal count, and it sets interrupt pending (slot 1 bit5).
- R4: At terminal count, with mode bit7 = 0 the count becomes 0 and the running flag clears. With mode bit7 = 1 the count reloads the time constant and the channel keeps running.
- R5: With mode bit2 = 1, a start while running reloads the count at once. With mode bit2 = 0 such a start is ignored and the count keeps falling.
- R6: With mode bit5 = 1 the count steps only on rising edges of `cnt_in`.
- R7: With mode bit4 = 1 a rising edge of `trg_in` acts as a start while the gate bit is 1. With mode bit4 = 0, `trg_in` has no effect.
- R8: With mode bit3 = 1 counting pauses while `gate_in` is 0. Clearing the gate bit (slot 1 bit2) also pauses counting.
- R9: `ct_out` is 0 unless mode bit6 = 1. Mode bits1:0 select the shape:
  - 0: one cycle high, beginning just after the terminal-count edge.
  - 1: high from the start until terminal count.
  - 2: toggles at each terminal count and starts low from idle.
  - 3: always low.
- R10: Writing slot 1 with bit3 = 1 freezes the count seen in slots 4/5 and sets slot 1 bit3. A read strobe (`reg_rd`) on slot 5 releases the freeze.
- R11: Slot 1 write bits7:5 are commands:
  - 1: clear pending and in-service
  - 2: set in-service (bit7)
  - 3: clear in-service
  - 4: set pending
  - 5: clear pending
  - 6: set enable (bit6)
  - 7: clear enable

  `irq` = pending AND enable AND NOT in-service.
- R12: A terminal count while pending is already set raises the error flag (slot 1 bit4). Commands 1 and 5 clear it.
- R13: While `chan_enable` is 0 the whole slot-1 byte is held at zero, counting stops, and writes to slot 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_enable | input | 1 | Channel enable; low clears control/status |
| cnt_in | input | 1 | External count pin |
| trg_in | input | 1 | External start pin |
| gate_in | input | 1 | External gate pin |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used to release a freeze) |
| reg_sel | input | 3 | Register slot select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected slot (combinational) |
| ct_out | output | 1 | Shaped timer output |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a terminal count that arrives while an earlier one is still pending. This is the only way to raise the error flag. The bench reaches it by running in continuous mode with a time constant of 2 and leaving the first pending flag unacknowledged, so a second terminal count lands two cycles later. The count freeze also needs care, because the count keeps falling underneath it. The bench reads the live value one cycle before the freeze write and then waits several cycles. It expects the frozen bytes to equal that earlier value, and after the releasing read it expects a lower live value.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

    localparam int BYTE_W = 8;
    localparam int SEL_W  = 3;

    localparam logic [SEL_W-1:0] SEL_MODE   = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_RLD_HI = 3'd2;
    localparam logic [SEL_W-1:0] SEL_RLD_LO = 3'd3;
    localparam logic [SEL_W-1:0] SEL_CNT_HI = 3'd4;
    localparam logic [SEL_W-1:0] SEL_CNT_LO = 3'd5;

    typedef enum logic [1:0] {
        DC_PULSE   = 2'd0,
        DC_ONESHOT = 2'd1,
        DC_SQUARE  = 2'd2,
        DC_RSVD    = 2'd3
    } duty_e;

    typedef struct packed {
        logic  contin;
        logic  out_en;
        logic  ext_cnt;
        logic  ext_trg;
        logic  ext_gate;
        logic  retrig;
        duty_e duty;
    } mode_t;

    typedef enum logic [2:0] {
        CMD_NULL       = 3'd0,
        CMD_CLR_IP_IUS = 3'd1,
        CMD_SET_IUS    = 3'd2,
        CMD_CLR_IUS    = 3'd3,
        CMD_SET_IP     = 3'd4,
        CMD_CLR_IP     = 3'd5,
        CMD_SET_IE     = 3'd6,
        CMD_CLR_IE     = 3'd7
    } cmd_e;

    typedef struct packed {
        logic ius;
        logic ie;
        logic ip;
        logic err;
    } flags_t;

    function automatic logic [BYTE_W-1:0] ctrl_byte(flags_t f, logic rcc, logic gcb, logic cip);
        return {f.ius, f.ie, f.ip, f.err, rcc, gcb, 1'b0, cip};
    endfunction

endpackage

// File: rtl/ctc_edge.sv
module ctc_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic prev_q;
        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= lvl[g];
        end
        assign rise[g] = lvl[g] & ~prev_q;
    end
endmodule

// File: rtl/ctc_core.sv
module ctc_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             trig,
    input  logic             tick,
    input  logic             run,
    input  logic             contin,
    input  logic             retrig,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             cip,
    output logic             load,
    output logic             tc
);
    logic [CNT_W-1:0] count_q;
    logic             cip_q;
    logic             at_end;
    logic             step;

    assign load   = trig && (!cip_q || retrig);
    assign at_end = (count_q < CNT_W'(2));
    assign step   = enable && cip_q && run && tick && !load;
    assign tc     = step && at_end;
    assign count  = count_q;
    assign cip    = cip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            cip_q   <= 1'b0;
        end else if (!enable) begin
            cip_q   <= 1'b0;
        end else if (load) begin
            count_q <= reload;
            cip_q   <= 1'b1;
        end else if (step) begin
            if (at_end) begin
                if (contin) begin
                    count_q <= reload;
                end else begin
                    count_q <= '0;
                    cip_q   <= 1'b0;
                end
            end else begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (cip_q && count_q == $past(reload)));

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !at_end) |=> (count_q == CNT_W'($past(count_q) - 1'b1)));

    assert_single_stop_R4: assert property (@(posedge clk) disable iff (rst)
        (tc && !contin) |=> (!cip_q && count_q == '0));

    assert_contin_reload_R4: assert property (@(posedge clk) disable iff (rst)
        (tc && contin) |=> (cip_q && count_q == $past(reload)));
endmodule

// File: rtl/ctc_wave.sv
module ctc_wave
    import ctc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  duty_e duty,
    input  logic  out_en,
    input  logic  load,
    input  logic  cip,
    input  logic  tc,
    output logic  out
);
    logic pulse_q, shot_q, sq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
            shot_q  <= 1'b0;
            sq_q    <= 1'b0;
        end else begin
            pulse_q <= tc;
            if (load)    shot_q <= 1'b1;
            else if (tc) shot_q <= 1'b0;
            if (load && !cip) sq_q <= 1'b0;
            else if (tc)      sq_q <= ~sq_q;
        end
    end

    always_comb begin
        out = 1'b0;
        if (out_en) begin
            case (duty)
                DC_PULSE:   out = pulse_q;
                DC_ONESHOT: out = shot_q;
                DC_SQUARE:  out = sq_q;
                default:    out = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/ctc_status.sv
module ctc_status
    import ctc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   enable,
    input  logic   cmd_wr,
    input  cmd_e   cmd,
    input  logic   tc,
    output flags_t flags
);
    flags_t f_q, f_cmd, f_nxt;

    always_comb begin
        f_cmd = f_q;
        if (cmd_wr) begin
            case (cmd)
                CMD_CLR_IP_IUS: begin f_cmd.ip = 1'b0; f_cmd.ius = 1'b0; f_cmd.err = 1'b0; end
                CMD_SET_IUS:    f_cmd.ius = 1'b1;
                CMD_CLR_IUS:    f_cmd.ius = 1'b0;
                CMD_SET_IP:     f_cmd.ip  = 1'b1;
                CMD_CLR_IP:     begin f_cmd.ip = 1'b0; f_cmd.err = 1'b0; end
                CMD_SET_IE:     f_cmd.ie  = 1'b1;
                CMD_CLR_IE:     f_cmd.ie  = 1'b0;
                default:        f_cmd = f_q;
            endcase
        end
        f_nxt = f_cmd;
        if (tc) begin
            f_nxt.err = f_cmd.err | f_cmd.ip;
            f_nxt.ip  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) f_q <= '0;
        else                f_q <= f_nxt;
    end

    assign flags = f_q;

    assert_tc_sets_ip_R3: assert property (@(posedge clk) disable iff (rst)
        tc |=> f_q.ip);

    assert_err_on_overrun_R12: assert property (@(posedge clk) disable iff (rst)
        (tc && f_q.ip && !cmd_wr) |=> f_q.err);

    assert_ack_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (enable && cmd_wr && cmd == CMD_CLR_IP_IUS && !tc) |=> (!f_q.ip && !f_q.ius));
endmodule

// File: rtl/ctc_channel.sv
module ctc_channel
    import ctc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_enable,
    input  logic              cnt_in,
    input  logic              trg_in,
    input  logic              gate_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              ct_out,
    output logic              irq
);
    localparam int NUM_PINS = 2;
    localparam int HI_LSB   = CNT_W - BYTE_W;

    mode_t            mode_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] view;
    logic             gcb_q, rcc_q;
    logic             wr_ctrl, gcb_nxt, sw_trig, hw_trig, trig, tick, run;
    logic             cip, load, tc;
    logic [NUM_PINS-1:0] pin_rise;
    flags_t           flags;
    logic [BYTE_W-1:0] ctrl_rd;

    ctc_edge #(.N(NUM_PINS)) u_edge (
        .clk (clk),
        .rst (rst),
        .lvl ({trg_in, cnt_in}),
        .rise(pin_rise)
    );

    assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL) && chan_enable;
    assign gcb_nxt = wr_ctrl ? reg_wdata[2] : gcb_q;
    assign sw_trig = wr_ctrl && reg_wdata[1];
    assign hw_trig = mode_q.ext_trg && pin_rise[1];
    assign trig    = chan_enable && gcb_nxt && (sw_trig || hw_trig);
    assign tick    = mode_q.ext_cnt ? pin_rise[0] : 1'b1;
    assign run     = gcb_q && (!mode_q.ext_gate || gate_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            reload_q <= '0;
        end else if (reg_wr) begin
            case (reg_sel)
                SEL_MODE:   mode_q <= mode_t'(reg_wdata);
                SEL_RLD_HI: reload_q[CNT_W-1:HI_LSB] <= reg_wdata;
                SEL_RLD_LO: reload_q[BYTE_W-1:0]     <= reg_wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !chan_enable) begin
            gcb_q <= 1'b0;
            rcc_q <= 1'b0;
            if (rst) hold_q <= '0;
        end else begin
            gcb_q <= gcb_nxt;
            if (wr_ctrl && reg_wdata[3] && !rcc_q) begin
                rcc_q  <= 1'b1;
                hold_q <= count;
            end else if (reg_rd && reg_sel == SEL_CNT_LO && rcc_q) begin
                rcc_q  <= 1'b0;
            end
        end
    end

    ctc_core #(.CNT_W(CNT_W)) u_core (
        .clk   (clk),
        .rst   (rst),
        .enable(chan_enable),
        .trig  (trig),
        .tick  (tick),
        .run   (run),
        .contin(mode_q.contin),
        .retrig(mode_q.retrig),
        .reload(reload_q),
        .count (count),
        .cip   (cip),
        .load  (load),
        .tc    (tc)
    );

    ctc_status u_status (
        .clk   (clk),
        .rst   (rst),
        .enable(chan_enable),
        .cmd_wr(wr_ctrl),
        .cmd   (cmd_e'(reg_wdata[7:5])),
        .tc    (tc),
        .flags (flags)
    );

    ctc_wave u_wave (
        .clk   (clk),
        .rst   (rst),
        .duty  (mode_q.duty),
        .out_en(mode_q.out_en),
        .load  (load),
        .cip   (cip),
        .tc    (tc),
        .out   (ct_out)
    );

    assign view    = rcc_q ? hold_q : count;
    assign ctrl_rd = ctrl_byte(flags, rcc_q, gcb_q, cip);
    assign irq     = flags.ip && flags.ie && !flags.ius;

    always_comb begin
        case (reg_sel)
            SEL_MODE:   reg_rdata = mode_q;
            SEL_CTRL:   reg_rdata = ctrl_rd;
            SEL_RLD_HI: reg_rdata = reload_q[CNT_W-1:HI_LSB];
            SEL_RLD_LO: reg_rdata = reload_q[BYTE_W-1:0];
            SEL_CNT_HI: reg_rdata = view[CNT_W-1:HI_LSB];
            SEL_CNT_LO: reg_rdata = view[BYTE_W-1:0];
            default:    reg_rdata = '0;
        endcase
    end

    assert_disable_clears_R13: assert property (@(posedge clk) disable iff (rst)
        !chan_enable |=> (ctrl_rd == '0));

    assert_freeze_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (rcc_q && $past(rcc_q)) |-> (view == $past(view)));
endmodule

// File: tb/test_ctc_channel.sv
`timescale 1ns/1ps
module test_ctc_channel;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;
    localparam int NVEC       = 6;
    // {continuous, time constant}
    localparam logic [16:0] VEC [NVEC] = '{17'h00005, 17'h10003, 17'h00001,
                                           17'h10002, 17'h00009, 17'h00100};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chan_enable = 1'b1;
    logic       cnt_in = 1'b0, trg_in = 1'b0, gate_in = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_sel = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       ct_out, irq;

    int n_cmp = 0;
    int n_mis = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctc_channel i_ctc_channel (
        .clk(clk), .rst(rst), .chan_enable(chan_enable),
        .cnt_in(cnt_in), .trg_in(trg_in), .gate_in(gate_in),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ct_out(ct_out), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] v);
        reg_sel = s;
        #0.1;
        v = reg_rdata;
    endtask

    task automatic rd_count(output logic [15:0] v);
        logic [7:0] h, l;
        rd(3'd4, h);
        rd(3'd5, l);
        v = {h, l};
    endtask

    task automatic rd_ctrl(output logic [7:0] v);
        rd(3'd1, v);
    endtask

    task automatic off_pulse();
        chan_enable = 1'b0;
        @(negedge clk);
        chan_enable = 1'b1;
    endtask

    task automatic setup(input logic [7:0] m, input logic [15:0] n);
        off_pulse();
        wr(3'd0, m);
        wr(3'd2, n[15:8]);
        wr(3'd3, n[7:0]);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_mis++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end

    initial begin
        logic [15:0] cv, nv;
        logic [7:0]  b;
        logic        c;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int s = 0; s < 6; s++) begin
            rd(3'(s), b);
            chk("R1 slot reset", {8'd0, b}, 16'h0000);
        end
        chk("R1 ct_out reset", {15'd0, ct_out}, 16'h0);
        chk("R1 irq reset", {15'd0, irq}, 16'h0);

        // Table walk: R2 load, R3 step and TC, R4 single/continuous
        for (int i = 0; i < NVEC; i++) begin
            nv = VEC[i][15:0];
            c  = VEC[i][16];
            setup({c, 7'd0}, nv);
            wr(3'd1, 8'h06);
            rd_count(cv);
            chk("R2 load on start", cv, nv);
            tick(int'(nv) - 1);
            rd_count(cv);
            chk("R3 count before TC", cv, 16'h0001);
            rd_ctrl(b);
            chk("R3 no pending before TC", {15'd0, b[5]}, 16'h0);
            tick(1);
            rd_ctrl(b);
            chk("R3 pending at TC", {15'd0, b[5]}, 16'h1);
            chk("R4 running after TC", {15'd0, b[0]}, {15'd0, c});
            rd_count(cv);
            chk("R4 count after TC", cv, c ? nv : 16'h0000);
        end

        // R2: start ignored without gate bit, and while disabled
        setup(8'h00, 16'd7);
        wr(3'd1, 8'h02);
        rd_ctrl(b);
        chk("R2 start without gate", {15'd0, b[0]}, 16'h0);
        chan_enable = 1'b0;
        wr(3'd1, 8'h06);
        rd_ctrl(b);
        chk("R13 write while disabled", {8'd0, b}, 16'h0000);
        chan_enable = 1'b1;

        // R5 retrigger
        setup(8'h04, 16'd10);
        wr(3'd1, 8'h06);
        tick(3);
        wr(3'd1, 8'h06);
        rd_count(cv);
        chk("R5 retrigger reloads", cv, 16'd10);
        setup(8'h00, 16'd10);
        wr(3'd1, 8'h06);
        tick(3);
        wr(3'd1, 8'h06);
        rd_count(cv);
        chk("R5 restart ignored", cv, 16'd6);

        // R6 external count
        setup(8'h20, 16'd4);
        wr(3'd1, 8'h06);
        tick(5);
        rd_count(cv);
        chk("R6 no edges no count", cv, 16'd4);
        for (int k = 0; k < 2; k++) begin
            cnt_in = 1'b1; @(negedge clk);
            cnt_in = 1'b0; @(negedge clk);
        end
        rd_count(cv);
        chk("R6 two edges", cv, 16'd2);

        // R7 external trigger
        setup(8'h10, 16'd6);
        wr(3'd1, 8'h04);
        rd_ctrl(b);
        chk("R7 armed not running", {15'd0, b[0]}, 16'h0);
        trg_in = 1'b1; @(negedge clk); trg_in = 1'b0;
        rd_count(cv);
        chk("R7 pin start loads", cv, 16'd6);
        setup(8'h00, 16'd6);
        wr(3'd1, 8'h04);
        trg_in = 1'b1; @(negedge clk); trg_in = 1'b0;
        rd_ctrl(b);
        chk("R7 pin ignored when off", {15'd0, b[0]}, 16'h0);

        // R8 gating
        gate_in = 1'b0;
        setup(8'h08, 16'd8);
        wr(3'd1, 8'h06);
        tick(4);
        rd_count(cv);
        chk("R8 gate pin low holds", cv, 16'd8);
        gate_in = 1'b1;
        tick(2);
        rd_count(cv);
        chk("R8 gate pin high counts", cv, 16'd6);
        wr(3'd1, 8'h00);
        tick(3);
        rd_count(cv);
        chk("R8 gate bit clear holds", cv, 16'd5);
        gate_in = 1'b0;

        // R9 output shapes
        setup(8'h40, 16'd3);
        wr(3'd1, 8'h06);
        tick(2);
        chk("R9 pulse low before TC", {15'd0, ct_out}, 16'h0);
        tick(1);
        chk("R9 pulse high after TC", {15'd0, ct_out}, 16'h1);
        tick(1);
        chk("R9 pulse one cycle", {15'd0, ct_out}, 16'h0);

        setup(8'h41, 16'd3);
        wr(3'd1, 8'h06);
        chk("R9 one-shot high at start", {15'd0, ct_out}, 16'h1);
        tick(2);
        chk("R9 one-shot held", {15'd0, ct_out}, 16'h1);
        tick(1);
        chk("R9 one-shot ends at TC", {15'd0, ct_out}, 16'h0);

        setup(8'hC2, 16'd2);
        wr(3'd1, 8'h06);
        chk("R9 square starts low", {15'd0, ct_out}, 16'h0);
        tick(2);
        chk("R9 square toggles high", {15'd0, ct_out}, 16'h1);
        tick(2);
        chk("R9 square toggles low", {15'd0, ct_out}, 16'h0);

        setup(8'hC3, 16'd1);
        wr(3'd1, 8'h06);
        for (int k = 0; k < 4; k++) begin
            tick(1);
            chk("R9 reserved code quiet", {15'd0, ct_out}, 16'h0);
        end
        setup(8'h80, 16'd1);
        wr(3'd1, 8'h06);
        tick(2);
        chk("R9 output disabled quiet", {15'd0, ct_out}, 16'h0);

        // R10 freeze for byte-wise read
        setup(8'h00, 16'h1234);
        wr(3'd1, 8'h06);
        tick(3);
        rd_count(cv);
        chk("R10 live before freeze", cv, 16'h1231);
        wr(3'd1, 8'h0C);
        tick(5);
        rd_ctrl(b);
        chk("R10 freeze flag set", {15'd0, b[3]}, 16'h1);
        rd_count(cv);
        chk("R10 frozen value", cv, 16'h1231);
        reg_rd = 1'b1; reg_sel = 3'd5;
        @(negedge clk);
        reg_rd = 1'b0;
        rd_ctrl(b);
        chk("R10 freeze released", {15'd0, b[3]}, 16'h0);
        rd_count(cv);
        chk("R10 live after release", cv, 16'h122A);

        // R11 interrupt commands
        off_pulse();
        wr(3'd1, 8'hC0);
        rd_ctrl(b);
        chk("R11 set enable", {8'd0, b}, 16'h0040);
        wr(3'd1, 8'h80);
        chk("R11 irq on pending", {15'd0, irq}, 16'h1);
        wr(3'd1, 8'h40);
        chk("R11 in-service masks irq", {15'd0, irq}, 16'h0);
        wr(3'd1, 8'h60);
        chk("R11 clear in-service", {15'd0, irq}, 16'h1);
        wr(3'd1, 8'hA0);
        rd_ctrl(b);
        chk("R11 clear pending", {8'd0, b}, 16'h0040);
        wr(3'd1, 8'h80);
        wr(3'd1, 8'h40);
        wr(3'd1, 8'h20);
        rd_ctrl(b);
        chk("R11 clear pending and in-service", {8'd0, b}, 16'h0040);
        wr(3'd1, 8'hE0);
        rd_ctrl(b);
        chk("R11 clear enable", {8'd0, b}, 16'h0000);

        // R12 overrun error
        setup(8'h80, 16'd2);
        wr(3'd1, 8'h06);
        tick(2);
        rd_ctrl(b);
        chk("R12 first TC", {8'd0, b}, 16'h0025);
        tick(2);
        rd_ctrl(b);
        chk("R12 error on second TC", {15'd0, b[4]}, 16'h1);
        wr(3'd1, 8'h24);
        rd_ctrl(b);
        chk("R12 ack clears error", {14'd0, b[5], b[4]}, 16'h0);

        // R13 disable clears control/status
        setup(8'h00, 16'd50);
        wr(3'd1, 8'hC6);
        rd_ctrl(b);
        chk("R13 running before disable", {8'd0, b}, 16'h0045);
        chan_enable = 1'b0;
        @(negedge clk);
        rd_ctrl(b);
        chk("R13 cleared while disabled", {8'd0, b}, 16'h0000);
        rd_count(cv);
        tick(3);
        rd_count(nv);
        chk("R13 count halted", nv, cv);
        chan_enable = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule